// File: doc/BRIEF.md
# Stack push/pop micro-op sequencer

This block sits between the decoder and the execution stage of a small in-order RISC-V core. It takes one decoded compressed stack instruction (a push, a push that also sets up the frame pointer, a pop, a pop that returns, or a pop that clears a0 and returns). It turns that instruction into a series of single-register stack accesses and register write-back requests. Each request is issued on a micro-op port, one beat at a time, and each beat waits for the execution stage to accept it.

The instruction names a saved-register list through a 4-bit code and gives a 2-bit extra-frame immediate. An XLEN select chooses 4-byte or 8-byte register slots. The sequencer works out the list length and the frame size. It then emits the memory beats, with offsets taken from the current sp. After these come the frame-pointer set, the a0 clear, the sp adjustment and the return jump, each where the instruction calls for it. A one-cycle done pulse closes every legal instruction. A bad list code or kind is refused with an illegal pulse and produces no beats.

Top module: `stack_uop_seq`

## Requirements
- R1: Kind codes are 0 push, 1 push-with-fp, 2 pop, 3 pop-return, 4 pop-return-zero. Kind codes 5 to 7 are illegal, and so are list codes 0 to 3. An accepted illegal request gives `illegal` high for exactly the following cycle, and no micro-op or done follows.
- R2: List codes 4 to 14 select 1 to 11 registers (code minus 3), and code 15 selects 13 registers. A sequence issues exactly one memory beat per listed register.
- R3: The memory beats of a push are stores (op 0) in the order ra (x1), s0 (x8), s1 (x9), s2..s11 (x18..x27). Beat i uses offset -(i+1)*slot.
- R4: The slot size is 4 bytes when `req_wide` is 0 and 8 bytes when it is 1.
- R5: frame = roundup16(count*slot) + 16*imm. Every sequence issues one sp-add beat (op 2, reg x2) with offset -frame for the push kinds and +frame for the pop kinds. It comes after all memory beats.
- R6: A push-with-fp issues a frame-pointer set (op 3, reg x8, offset 0, meaning s0 = old sp) after the last store and before the sp-add.
- R7: The memory beats of a pop are loads (op 1), in the same register order as R3. Beat i uses offset frame-(i+1)*slot.
- R8: A pop-return issues the sp-add and then a return (op 5, reg x1, offset 0). A pop-return-zero issues an a0 clear (op 4, reg x10, offset 0), then the sp-add, then the return. The return is always the last beat.
- R9: While `uop_valid` is high and `uop_ready` is low, the beat holds with op, reg and offset unchanged. The sequence advances only on a handshake.
- R10: `req_ready` is low from a legal acceptance until the sequence ends. `done` is high for exactly the one cycle after the final handshake.
- R11: After reset, `req_ready` is high and `uop_valid`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Decoded instruction present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_kind | input | 3 | Instruction kind code |
| req_rlist | input | 4 | Saved-register list code |
| req_spimm | input | 2 | Extra frame size in 16-byte units |
| req_wide | input | 1 | 1 selects 8-byte slots, 0 selects 4-byte slots |
| uop_valid | output | 1 | Micro-op beat present |
| uop_ready | input | 1 | Execution stage takes the beat |
| uop_op | output | 3 | Micro-op code |
| uop_reg | output | 5 | Architectural register index |
| uop_off | output | 12 | Signed offset from sp or sp delta |
| done | output | 1 | Sequence finished pulse |
| illegal | output | 1 | Refused request pulse |

## Verification
The assertions assume that `uop_ready` may drop in any cycle, and that request fields matter only in the cycle a request is taken. They also assume that the list code and kind are sampled only on acceptance and are free to change afterwards. The bench presents a request only while `req_ready` is high and drops `req_valid` right after the taking edge. On alternate table entries it withholds `uop_ready` in a fixed pattern, so that stalls fall on memory beats as well as on the trailing write-back beats.

// File: rtl/stack_uop_pkg.sv
package stack_uop_pkg;
    localparam int REG_W    = 5;
    localparam int OFF_W    = 12;
    localparam int CNT_W    = 4;
    localparam int MAX_REGS = 13;
    localparam int FRAME_W  = 9;

    localparam logic [REG_W-1:0] X_RA = REG_W'(1);
    localparam logic [REG_W-1:0] X_SP = REG_W'(2);
    localparam logic [REG_W-1:0] X_S0 = REG_W'(8);
    localparam logic [REG_W-1:0] X_A0 = REG_W'(10);

    typedef enum logic [2:0] {
        K_PUSH    = 3'd0,
        K_PUSHFP  = 3'd1,
        K_POP     = 3'd2,
        K_POPRET  = 3'd3,
        K_POPRETZ = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        OP_STORE  = 3'd0,
        OP_LOAD   = 3'd1,
        OP_SPADD  = 3'd2,
        OP_FPSET  = 3'd3,
        OP_A0ZERO = 3'd4,
        OP_RET    = 3'd5
    } uop_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MEM,
        PH_FP,
        PH_A0,
        PH_SP,
        PH_RET
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        kind_e              kind;
        logic               wide;
        logic [CNT_W-1:0]   count;
        logic [CNT_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
        logic               done;
        logic               illegal;
    } seq_s;
endpackage

// File: rtl/stack_rlist_dec.sv
module stack_rlist_dec
    import stack_uop_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int IMM_W  = 2
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [IMM_W-1:0]   spimm,
    input  logic               wide,
    output logic               legal,
    output logic [CNT_W-1:0]   count,
    output logic [FRAME_W-1:0] frame
);
    localparam int FIRST_CODE = 4;
    localparam int CODE_BIAS  = FIRST_CODE - 1;
    localparam logic [CODE_W-1:0] TOP_CODE = '1;

    logic [FRAME_W-1:0] slot_b;
    logic [FRAME_W-1:0] save_b;
    logic [FRAME_W-1:0] round_b;

    always_comb begin
        legal = (code >= CODE_W'(FIRST_CODE));
        if (code == TOP_CODE) begin
            count = CNT_W'(MAX_REGS);
        end else if (legal) begin
            count = CNT_W'(code - CODE_W'(CODE_BIAS));
        end else begin
            count = '0;
        end
        slot_b  = wide ? FRAME_W'(8) : FRAME_W'(4);
        save_b  = FRAME_W'(count) * slot_b;
        round_b = (save_b + FRAME_W'(15)) & ~FRAME_W'(15);
        frame   = round_b + (FRAME_W'(spimm) << 4);
    end
endmodule

// File: rtl/stack_slot_map.sv
module stack_slot_map
    import stack_uop_pkg::*;
(
    input  logic [CNT_W-1:0]          idx,
    input  logic                      wide,
    input  logic [FRAME_W-1:0]        frame,
    output logic [REG_W-1:0]          reg_num,
    output logic signed [OFF_W-1:0]   st_off,
    output logic signed [OFF_W-1:0]   ld_off
);
    logic [REG_W-1:0] reg_tab [MAX_REGS];

    for (genvar g = 0; g < MAX_REGS; g++) begin : g_tab
        assign reg_tab[g] = REG_W'(g == 0 ? 1 : (g < 3 ? g + 7 : g + 15));
    end

    logic [OFF_W-1:0] depth_u;
    logic [OFF_W-1:0] frame_u;

    always_comb begin
        reg_num = (int'(idx) < MAX_REGS) ? reg_tab[idx] : '0;
        depth_u = (OFF_W'(idx) + OFF_W'(1)) << (wide ? 3 : 2);
        frame_u = OFF_W'(frame);
        st_off  = -$signed(depth_u);
        ld_off  = $signed(frame_u) - $signed(depth_u);
    end
endmodule

// File: rtl/stack_uop_seq.sv
module stack_uop_seq
    import stack_uop_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int IMM_W  = 2,
    parameter int KIND_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [KIND_W-1:0]        req_kind,
    input  logic [CODE_W-1:0]        req_rlist,
    input  logic [IMM_W-1:0]         req_spimm,
    input  logic                     req_wide,
    output logic                     uop_valid,
    input  logic                     uop_ready,
    output logic [2:0]               uop_op,
    output logic [REG_W-1:0]         uop_reg,
    output logic signed [OFF_W-1:0]  uop_off,
    output logic                     done,
    output logic                     illegal
);
    seq_s s_q, s_d;

    logic               dec_legal;
    logic [CNT_W-1:0]   dec_count;
    logic [FRAME_W-1:0] dec_frame;

    stack_rlist_dec #(.CODE_W(CODE_W), .IMM_W(IMM_W)) dec_i (
        .code  (req_rlist),
        .spimm (req_spimm),
        .wide  (req_wide),
        .legal (dec_legal),
        .count (dec_count),
        .frame (dec_frame)
    );

    logic [REG_W-1:0]        map_reg;
    logic signed [OFF_W-1:0] map_st;
    logic signed [OFF_W-1:0] map_ld;

    stack_slot_map map_i (
        .idx     (s_q.idx),
        .wide    (s_q.wide),
        .frame   (s_q.frame),
        .reg_num (map_reg),
        .st_off  (map_st),
        .ld_off  (map_ld)
    );

    logic                    is_push;
    logic                    has_ret;
    logic                    accept;
    logic                    beat;
    logic                    kind_ok;
    logic                    last_mem;
    logic [OFF_W-1:0]        frame_u;
    logic signed [OFF_W-1:0] frame_s;
    phase_e                  after_mem;

    always_comb begin
        is_push   = (s_q.kind == K_PUSH) || (s_q.kind == K_PUSHFP);
        has_ret   = (s_q.kind == K_POPRET) || (s_q.kind == K_POPRETZ);
        frame_u   = OFF_W'(s_q.frame);
        frame_s   = $signed(frame_u);
        last_mem  = ((s_q.idx + CNT_W'(1)) == s_q.count);
        kind_ok   = (req_kind <= KIND_W'(K_POPRETZ));

        case (s_q.kind)
            K_PUSHFP:  after_mem = PH_FP;
            K_POPRETZ: after_mem = PH_A0;
            default:   after_mem = PH_SP;
        endcase

        req_ready = (s_q.phase == PH_IDLE);
        uop_valid = (s_q.phase != PH_IDLE);
        accept    = req_valid && req_ready;
        beat      = uop_valid && uop_ready;

        uop_op  = OP_STORE;
        uop_reg = '0;
        uop_off = '0;
        case (s_q.phase)
            PH_MEM: begin
                uop_op  = is_push ? OP_STORE : OP_LOAD;
                uop_reg = map_reg;
                uop_off = is_push ? map_st : map_ld;
            end
            PH_FP: begin
                uop_op  = OP_FPSET;
                uop_reg = X_S0;
            end
            PH_A0: begin
                uop_op  = OP_A0ZERO;
                uop_reg = X_A0;
            end
            PH_SP: begin
                uop_op  = OP_SPADD;
                uop_reg = X_SP;
                uop_off = is_push ? -frame_s : frame_s;
            end
            PH_RET: begin
                uop_op  = OP_RET;
                uop_reg = X_RA;
            end
            default: ;
        endcase

        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.illegal = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (dec_legal && kind_ok) begin
                        s_d.phase = PH_MEM;
                        s_d.kind  = kind_e'(req_kind);
                        s_d.wide  = req_wide;
                        s_d.count = dec_count;
                        s_d.idx   = '0;
                        s_d.frame = dec_frame;
                    end else begin
                        s_d.illegal = 1'b1;
                    end
                end
            end
            PH_MEM: begin
                if (beat) begin
                    if (last_mem) begin
                        s_d.phase = after_mem;
                    end else begin
                        s_d.idx = s_q.idx + CNT_W'(1);
                    end
                end
            end
            PH_FP, PH_A0: begin
                if (beat) s_d.phase = PH_SP;
            end
            PH_SP: begin
                if (beat) begin
                    if (has_ret) begin
                        s_d.phase = PH_RET;
                    end else begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end
                end
            end
            PH_RET: begin
                if (beat) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase

        done    = s_q.done;
        illegal = s_q.illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, kind: K_PUSH, wide: 1'b0, count: '0,
                     idx: '0, frame: '0, done: 1'b0, illegal: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/stack_uop_seq_chk.sv
module stack_uop_seq_chk
    import stack_uop_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     uop_valid,
    input logic                     uop_ready,
    input logic [2:0]               uop_op,
    input logic [REG_W-1:0]         uop_reg,
    input logic signed [OFF_W-1:0]  uop_off,
    input logic                     done,
    input logic                     illegal
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op)
            && $stable(uop_reg) && $stable(uop_off)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (illegal || !req_ready));

    // R10
    busy_while_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !req_ready);

    // R1
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!uop_valid && !done));

    // R8
    ret_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_op == OP_RET) |=> done);

    // R6
    fp_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_op == OP_FPSET) |-> (uop_reg == X_S0 && uop_off == 0));

    // R3
    store_below_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_op == OP_STORE) |-> (uop_off < 0));
endmodule

bind stack_uop_seq stack_uop_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .uop_valid (uop_valid),
    .uop_ready (uop_ready),
    .uop_op    (uop_op),
    .uop_reg   (uop_reg),
    .uop_off   (uop_off),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/stack_uop_seq_tb_top.sv
`timescale 1ns/1ps
module stack_uop_seq_tb_top;
    import stack_uop_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [2:0]              req_kind = '0;
    logic [3:0]              req_rlist = '0;
    logic [1:0]              req_spimm = '0;
    logic                    req_wide = 1'b0;
    logic                    uop_valid;
    logic                    uop_ready = 1'b1;
    logic [2:0]              uop_op;
    logic [REG_W-1:0]        uop_reg;
    logic signed [OFF_W-1:0] uop_off;
    logic                    done;
    logic                    illegal;

    always #2.5 clk = ~clk;

    stack_uop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_rlist(req_rlist), .req_spimm(req_spimm),
        .req_wide(req_wide), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_op(uop_op), .uop_reg(uop_reg), .uop_off(uop_off),
        .done(done), .illegal(illegal)
    );

    int total = 0;
    int bad = 0;
    int wd_cycles = 0;

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd_cycles, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // {wide, kind, list code, imm}
    localparam int NV = 10;
    localparam logic [9:0] VECS [NV] = '{
        {1'b0, 3'd0, 4'd4,  2'd0},
        {1'b1, 3'd0, 4'd15, 2'd3},
        {1'b0, 3'd1, 4'd6,  2'd1},
        {1'b1, 3'd2, 4'd14, 2'd0},
        {1'b0, 3'd3, 4'd9,  2'd2},
        {1'b1, 3'd4, 4'd7,  2'd1},
        {1'b0, 3'd4, 4'd15, 2'd0},
        {1'b1, 3'd1, 4'd5,  2'd2},
        {1'b0, 3'd0, 4'd14, 2'd3},
        {1'b0, 3'd2, 4'd15, 2'd1}
    };

    int    e_op [20];
    int    e_reg [20];
    int    e_off [20];
    string e_tag [20];
    int    e_n;

    function automatic int bench_reg(input int i);
        if (i == 0) return 1;
        if (i == 1) return 8;
        if (i == 2) return 9;
        return 18 + (i - 3);
    endfunction

    task automatic add_beat(input int op, input int r, input int off, input string tag);
        e_op[e_n] = op; e_reg[e_n] = r; e_off[e_n] = off; e_tag[e_n] = tag;
        e_n++;
    endtask

    task automatic build(input int kind, input int code, input int imm, input bit w);
        int n, slot, frame;
        bit push;
        n     = (code == 15) ? 13 : code - 3;
        slot  = w ? 8 : 4;
        frame = ((n * slot + 15) / 16) * 16 + imm * 16;
        push  = (kind <= 1);
        e_n   = 0;
        for (int i = 0; i < n; i++) begin
            if (push) add_beat(0, bench_reg(i), -(i + 1) * slot, "R3 R4");
            else      add_beat(1, bench_reg(i), frame - (i + 1) * slot, "R7 R4");
        end
        if (kind == 1) add_beat(3, 8, 0, "R6");
        if (kind == 4) add_beat(4, 10, 0, "R8");
        add_beat(2, 2, push ? -frame : frame, "R5");
        if (kind >= 3) add_beat(5, 1, 0, "R8");
    endtask

    task automatic run_seq(input int kind, input int code, input int imm, input bit w, input bit stall);
        int  k = 0;
        bit  seen_done = 0;
        bit  hold = 0;
        int  h_op = 0, h_reg = 0, h_off = 0;
        build(kind, code, imm, w);
        @(negedge clk);
        req_kind = 3'(kind); req_rlist = 4'(code); req_spimm = 2'(imm); req_wide = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_rlist = 4'd0;
        for (int cyc = 0; cyc < 100; cyc++) begin
            uop_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (done) begin
                seen_done = 1;
                break;
            end
            check_eq("R10", "req_ready busy", int'(req_ready), 0);
            if (hold) begin
                check_eq("R9", "held op", int'(uop_op), h_op);
                check_eq("R9", "held reg", int'(uop_reg), h_reg);
                check_eq("R9", "held off", int'(uop_off), h_off);
            end
            hold = 0;
            if (uop_valid) begin
                if (uop_ready) begin
                    if (k < e_n) begin
                        check_eq(e_tag[k], "op", int'(uop_op), e_op[k]);
                        check_eq(e_tag[k], "reg", int'(uop_reg), e_reg[k]);
                        check_eq(e_tag[k], "off", int'(uop_off), e_off[k]);
                    end
                    k++;
                end else begin
                    hold = 1;
                    h_op = int'(uop_op); h_reg = int'(uop_reg); h_off = int'(uop_off);
                end
            end
            @(negedge clk);
        end
        uop_ready = 1'b1;
        check_eq("R10", "done seen", int'(seen_done), 1);
        check_eq("R2", "beat count", k, e_n);
        check_eq("R10", "ready at done", int'(req_ready), 1);
        @(negedge clk);
        check_eq("R10", "done width", int'(done), 0);
    endtask

    task automatic run_illegal(input int kind, input int code);
        @(negedge clk);
        req_kind = 3'(kind); req_rlist = 4'(code); req_spimm = 2'd1; req_wide = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R1", "illegal flag", int'(illegal), 1);
        check_eq("R1", "no beat", int'(uop_valid), 0);
        @(negedge clk);
        check_eq("R1", "illegal width", int'(illegal), 0);
        check_eq("R1", "no beat later", int'(uop_valid), 0);
        check_eq("R1", "no done", int'(done), 0);
        check_eq("R1", "still ready", int'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check_eq("R11", "req_ready", int'(req_ready), 1);
        check_eq("R11", "uop_valid", int'(uop_valid), 0);
        check_eq("R11", "done", int'(done), 0);
        check_eq("R11", "illegal", int'(illegal), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_seq(int'(VECS[v][8:6]), int'(VECS[v][5:2]), int'(VECS[v][1:0]),
                    VECS[v][9], (v % 2) == 1);
        end

        // R1: refused list codes and kind codes
        run_illegal(0, 0);
        run_illegal(2, 3);
        run_illegal(6, 8);

        // R2: shortest list on the wider slot, stalled
        run_seq(3, 4, 3, 1'b1, 1'b1);
        // R4: same list in both slot sizes
        run_seq(0, 10, 0, 1'b0, 1'b0);
        run_seq(0, 10, 0, 1'b1, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule